// File: doc/BRIEF.md
# Debug Comparator Privilege Qualifier

This block sits behind a breakpoint or watchpoint comparator whose address (or data access) compare has already produced a raw hit. It decides whether that hit is a real debug event by applying three filters from fields of the comparator's 64-bit control word. The first filter is on the processor's security state. The second is on the exception level the access is judged at. The third, when enabled, requires a linked context comparator to agree.

The same field layout serves breakpoints and watchpoints. The only difference is for watchpoints: a load or store flagged as unprivileged is judged as if it were made at EL0. The block presents the requested link number to an external context matcher and takes back that matcher's verdict in the same cycle. The qualified result is registered and appears one clock after the inputs.

All pins are plain control and status signals. No data stream crosses this block, so it has no valid/ready handshake and no back-pressure.

Top module: `dbgq_qualifier`

## Requirements
- R1: While reset is asserted and on the first sample after it is released, `match_q` is 0.
- R2: When `raw_hit` is 0, `match_q` is 0 in the following cycle, whatever the other inputs are.
- R3: The security field is `ctrl[15:14]`. A value of 1 or 3 rejects the event when `secure` is 1. A value of 2 rejects it when `secure` is 0. A value of 0 applies no security filter.
- R4: When the effective level is 2 or 3, the event is rejected unless `ctrl[13]` (the high-level enable) is 1.
- R5: When the effective level is 1, the event needs `ctrl[1]`. When the effective level is 0, it needs `ctrl[2]`.
- R6: When `is_watch` is 1 and `unpriv_acc` is 1, the effective level is 0 whatever `cur_el` is. When `is_watch` is 0 (breakpoint), `unpriv_acc` has no effect and the effective level is `cur_el`.
- R7: When `ctrl[20]` (the link enable) is 1, the event is rejected unless `link_hit` is 1. When `ctrl[20]` is 0, `link_hit` has no effect.
- R8: `link_num` equals `ctrl[19:16]` combinationally, and it is presented in the same cycle as `ctrl`.
- R9: `match_q` at a clock edge equals the qualification of the inputs sampled at that edge, and no other bit of `ctrl` affects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raw_hit | input | 1 | Raw address or access hit from the comparator |
| ctrl | input | 64 | Comparator control word |
| secure | input | 1 | Processor is in secure state |
| cur_el | input | 2 | Current exception level |
| unpriv_acc | input | 1 | Watchpoint access came from an unprivileged load or store |
| is_watch | input | 1 | 1 selects watchpoint, 0 selects breakpoint |
| link_hit | input | 1 | Verdict of the linked context matcher for `link_num` |
| link_num | output | 4 | Link number requested from the context matcher |
| match_q | output | 1 | Registered qualified debug event |

## Verification
The hardest cases to reach are those where filters interact. Examples are an unprivileged watchpoint access at EL2 that must pass on the EL0 permission bit and ignore the high-level enable, or a breakpoint at the same level where the unprivileged flag must change nothing. The stimulus therefore sweeps every combination of every field the block decodes, along with the security, level, select, unprivileged and link-verdict inputs. Unrelated control bits are filled with a changing pattern so that their lack of effect is exercised along the way.

// File: rtl/dbgq_pkg.sv
package dbgq_pkg;
  localparam int CTRL_W    = 64;
  localparam int EL_W      = 2;
  localparam int LINK_W    = 4;
  localparam int PRIV_LO   = 1;
  localparam int HIGH_BIT  = 13;
  localparam int SEC_LO    = 14;
  localparam int LINK_LO   = 16;
  localparam int LINK_EN   = 20;

  typedef enum logic [1:0] {
    SEC_ANY    = 2'd0,
    SEC_NS_A   = 2'd1,
    SEC_ONLY_S = 2'd2,
    SEC_NS_B   = 2'd3
  } sec_sel_e;

  typedef struct packed {
    logic [1:0]        priv;
    logic              high_en;
    sec_sel_e          sec_sel;
    logic [LINK_W-1:0] link_num;
    logic              link_en;
  } qual_fields_t;
endpackage

// File: rtl/dbgq_field_decode.sv
module dbgq_field_decode
  import dbgq_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl,
  output qual_fields_t      fields
);
  always_comb begin
    fields.priv     = ctrl[PRIV_LO +: 2];
    fields.high_en  = ctrl[HIGH_BIT];
    fields.sec_sel  = sec_sel_e'(ctrl[SEC_LO +: 2]);
    fields.link_num = ctrl[LINK_LO +: LINK_W];
    fields.link_en  = ctrl[LINK_EN];
  end
endmodule

// File: rtl/dbgq_sec_filter.sv
module dbgq_sec_filter
  import dbgq_pkg::*;
(
  input  sec_sel_e sec_sel,
  input  logic     secure,
  output logic     sec_ok
);
  always_comb begin
    unique case (sec_sel)
      SEC_ANY:    sec_ok = 1'b1;
      SEC_ONLY_S: sec_ok = secure;
      default:    sec_ok = ~secure;
    endcase
  end
endmodule

// File: rtl/dbgq_level_filter.sv
module dbgq_level_filter
  import dbgq_pkg::*;
#(
  parameter int LVL_W = EL_W
) (
  input  logic [LVL_W-1:0] cur_el,
  input  logic             unpriv_acc,
  input  logic             is_watch,
  input  logic [1:0]       priv,
  input  logic             high_en,
  output logic             lvl_ok
);
  localparam int LVL_N = 1 << LVL_W;
  logic [LVL_W-1:0] eff_el;
  logic [LVL_N-1:0] allow;

  assign eff_el = (is_watch && unpriv_acc) ? '0 : cur_el;

  for (genvar g = 0; g < LVL_N; g++) begin : g_lvl
    if (g == 0) begin : g_el0
      assign allow[g] = priv[1];
    end else if (g == 1) begin : g_el1
      assign allow[g] = priv[0];
    end else begin : g_elhi
      assign allow[g] = high_en;
    end
  end

  assign lvl_ok = allow[eff_el];
endmodule

// File: rtl/dbgq_qualifier.sv
module dbgq_qualifier
  import dbgq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raw_hit,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              secure,
  input  logic [EL_W-1:0]   cur_el,
  input  logic              unpriv_acc,
  input  logic              is_watch,
  input  logic              link_hit,
  output logic [LINK_W-1:0] link_num,
  output logic              match_q
);
  qual_fields_t f;
  logic sec_ok, lvl_ok, link_ok, qual_d;

  dbgq_field_decode u_dec (.ctrl(ctrl), .fields(f));

  dbgq_sec_filter u_sec (.sec_sel(f.sec_sel), .secure(secure), .sec_ok(sec_ok));

  dbgq_level_filter #(.LVL_W(EL_W)) u_lvl (
    .cur_el(cur_el), .unpriv_acc(unpriv_acc), .is_watch(is_watch),
    .priv(f.priv), .high_en(f.high_en), .lvl_ok(lvl_ok)
  );

  assign link_num = f.link_num;
  assign link_ok  = ~f.link_en | link_hit;
  assign qual_d   = raw_hit & sec_ok & lvl_ok & link_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_q <= 1'b0;
    else        match_q <= qual_d;
  end
endmodule

// File: rtl/dbgq_checker.sv
module dbgq_checker
  import dbgq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              raw_hit,
  input logic [CTRL_W-1:0] ctrl,
  input logic              secure,
  input logic [EL_W-1:0]   cur_el,
  input logic              unpriv_acc,
  input logic              is_watch,
  input logic              link_hit,
  input logic              match_q
);
  logic as_el0;
  assign as_el0 = is_watch & unpriv_acc;

  a_r2_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !raw_hit |=> !match_q);

  a_r3_ns_only: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_hit && secure && ctrl[SEC_LO]) |=> !match_q);

  a_r3_s_only: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_hit && !secure && ctrl[SEC_LO +: 2] == 2'd2) |=> !match_q);

  a_r4_high_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_hit && !as_el0 && cur_el[1] && !ctrl[HIGH_BIT]) |=> !match_q);

  a_r5_el1_priv: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_hit && !as_el0 && cur_el == 2'd1 && !ctrl[PRIV_LO]) |=> !match_q);

  a_r6_unpriv_el0: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_hit && as_el0 && !ctrl[PRIV_LO+1]) |=> !match_q);

  a_r7_link: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_hit && ctrl[LINK_EN] && !link_hit) |=> !match_q);
endmodule

bind dbgq_qualifier dbgq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .raw_hit(raw_hit), .ctrl(ctrl), .secure(secure),
  .cur_el(cur_el), .unpriv_acc(unpriv_acc), .is_watch(is_watch),
  .link_hit(link_hit), .match_q(match_q)
);

// File: tb/sim_dbgq_qualifier.sv
module sim_dbgq_qualifier;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        raw_hit = 1'b0;
  logic [63:0] ctrl = '0;
  logic        secure = 1'b0;
  logic [1:0]  cur_el = '0;
  logic        unpriv_acc = 1'b0;
  logic        is_watch = 1'b0;
  logic        link_hit = 1'b0;
  logic [3:0]  link_num;
  logic        match_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbgq_qualifier u0 (
    .clk(clk), .rst_n(rst_n), .raw_hit(raw_hit), .ctrl(ctrl), .secure(secure),
    .cur_el(cur_el), .unpriv_acc(unpriv_acc), .is_watch(is_watch),
    .link_hit(link_hit), .link_num(link_num), .match_q(match_q)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = 1;
    #(CLK_PERIOD * 2);
    chk("R1 in reset", {31'd0, match_q}, 0);
    @(negedge clk);
    raw_hit = 1'b1;
    ctrl = 64'h6;
    rst_n = 1'b1;
    #1;
    chk("R1 after release", {31'd0, match_q}, 0);

    for (int i = 0; i < 8192; i++) begin
      logic r, s, w, u, lh, wt, hm, exp;
      logic [1:0] el, pac, ssc, eff;
      logic [3:0] ln;
      logic sec_pass, lvl_pass;
      string why;
      @(negedge clk);
      r   = i[0];
      s   = i[1];
      el  = i[3:2];
      u   = i[4];
      w   = i[5];
      pac = i[7:6];
      hm  = i[8];
      ssc = i[10:9];
      wt  = i[11];
      lh  = i[12];
      ln  = 4'(i * 7 + 3);
      seed = seed * 1103515245 + 12345;
      ctrl = {32'(seed), 11'(seed >>> 5), wt, ln, ssc, hm, 10'(seed >>> 9), pac, 1'(seed >>> 3)};
      raw_hit = r; secure = s; cur_el = el; unpriv_acc = u;
      is_watch = w; link_hit = lh;
      #1;
      chk("R8 link_num", {28'd0, link_num}, {28'd0, ln});

      sec_pass = (ssc == 2'd0) ? 1'b1 : (ssc == 2'd2) ? s : !s;
      eff = (w && u) ? 2'd0 : el;
      lvl_pass = (eff >= 2) ? hm : (eff == 1) ? pac[0] : pac[1];
      exp = r && sec_pass && lvl_pass && (!wt || lh);
      if (!r) why = "R2";
      else if (!sec_pass) why = "R3";
      else if (!lvl_pass) why = (w && u) ? "R6" : (el >= 2) ? "R4" : "R5";
      else if (wt) why = "R7";
      else why = "R9";

      @(posedge clk);
      #1;
      chk(why, {31'd0, match_q}, {31'd0, exp});
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule